// File: doc/BRIEF.md
# Multi-level radio frame timer

This block keeps radio time as three nested counts: clocks inside the current symbol, symbols inside the current frame, and a running frame number. The length of each symbol is not fixed. Every symbol position in the frame looks up its own clock terminal count in a small table, which is addressed by a 7-bit index that follows the symbol count. This lets one frame hold symbols of unequal length, as OFDM and TDD air interfaces need. A frame made of equal-length slots uses the same value in every table entry.

The timer stays idle after reset. It starts, and later resynchronises, on a pulse from one of three sources chosen by a select input: a software strobe, an external sync pulse, or a compare-match pulse from a companion timer. A sync clears the clock count, the symbol count and the table index, and loads the frame count from a programmable initial value. A one-cycle symbol strobe and a one-cycle frame strobe mark the boundaries for event logic further down the chain.

Terminal counts are written through a valid-only write port. The table accepts every write on the cycle it is presented, so the port never applies back-pressure and has no ready signal. Writes are allowed while the timer runs.

Top module: `radio_frame_timer`

## Requirements
- R1: After reset, and until the first sync, clock, symbol, frame and index outputs are all zero and both strobes are low.
- R2: `sync_sel` picks the sync source: 0 = software strobe `sw_sync`, 1 = external pulse `ext_sync`, 2 = compare match `cmp_sync`, 3 = none. Pulses on sources that are not selected have no effect on any output.
- R3: A pulse on the selected source in a cycle makes the next clock edge set clock count, symbol count and table index to zero, load the frame count from `init_frame`, and drive both strobes low. This holds whether the timer is idle or running.
- R4: While running, the 19-bit clock count rises by one per cycle. In the cycle after it has reached or passed the table entry addressed by the current index, it returns to zero.
- R5: Each clock-count wrap raises the 8-bit symbol count by one. `sym_strobe` is high for exactly the one cycle in which the new symbol's count (clock count 0) is first shown.
- R6: A clock-count wrap while the symbol count has reached or passed `sym_tc` returns the symbol count to zero and raises the 40-bit frame count by one. `frame_strobe` is high in that same first cycle, together with `sym_strobe`. Table entries all 9 with `sym_tc` = 14 give 15 symbols in 150 cycles per frame.
- R7: The table index follows the symbol count, saturates at 127, and returns to zero at each frame boundary.
- R8: Terminal counts use the full 19-bit range and may differ between symbols. Entries 1, 84479 and 1 for the first three symbols give symbol lengths of 2, 84480 and 2 cycles.
- R9: A write with `tc_wr_en` high stores `tc_wr_data` at `tc_wr_addr` at that clock edge. The stored value is used by every later lookup, including a lookup for a symbol of the frame already in progress.
- R10: The frame count wraps from 2^40-1 to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_sel | input | 2 | Sync source select (0 software, 1 external, 2 compare, 3 none) |
| sw_sync | input | 1 | Software sync strobe |
| ext_sync | input | 1 | External sync pulse |
| cmp_sync | input | 1 | Compare-match pulse from the companion timer |
| init_frame | input | 40 | Frame count loaded on sync |
| sym_tc | input | 8 | Last symbol number of a frame |
| tc_wr_en | input | 1 | Table write valid |
| tc_wr_addr | input | 7 | Table entry to write |
| tc_wr_data | input | 19 | Clock terminal count to store |
| clk_count | output | 19 | Clock count inside the symbol |
| sym_count | output | 8 | Symbol count inside the frame |
| frame_count | output | 40 | Frame number |
| tc_index | output | 7 | Table index in use |
| sym_strobe | output | 1 | First cycle of a new symbol |
| frame_strobe | output | 1 | First cycle of a new frame |

## Verification
The counters are driven through a table of short, unequal entries including a zero (a one-cycle symbol). This separates a per-symbol lookup from a single shared length and also catches off-by-one wraps. Sync pulses are applied on each source under every select value, both from idle and mid-frame, to show that only the chosen source loads the counters. A long `sym_tc` with one-cycle symbols drives the index into saturation. An all-ones initial frame exposes the 40-bit wrap. The long 84479 symbol, with a table rewrite made while that symbol is running, shows full-width counting and shows that writes reach the current frame.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam int CLK_W = 19;
  localparam int SYM_W = 8;
  localparam int FRM_W = 40;
  localparam int IDX_W = 7;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_EXT = 2'd1,
    SRC_CMP = 2'd2,
    SRC_OFF = 2'd3
  } sync_src_e;
endpackage

// File: rtl/rft_sync_mux.sv
module rft_sync_mux
  import rft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       sw_i,
  input  logic       ext_i,
  input  logic       cmp_i,
  output logic       sync_o
);
  sync_src_e src;
  assign src = sync_src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_SW:  sync_o = sw_i;
      SRC_EXT: sync_o = ext_i;
      SRC_CMP: sync_o = cmp_i;
      default: sync_o = 1'b0;
    endcase
  end

  // R2: with every source quiet, no sync is produced
  p_quiet_no_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_i && !ext_i && !cmp_i) |-> !sync_o);

  // R2: the disabled setting never syncs
  p_off_no_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'd3) |-> !sync_o);
endmodule

// File: rtl/rft_tc_table.sv
module rft_tc_table #(
  parameter int IDX_W = 7,
  parameter int CLK_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [CLK_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CLK_W-1:0] rd_tc_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CLK_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_tc_o = mem_q[rd_idx_i];

  // R9: a written entry is what a later lookup of that address returns
  p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !$isunknown(wr_addr_i)) |=>
      ((rd_idx_i != $past(wr_addr_i)) || (rd_tc_o == $past(wr_data_i))
       || (wr_en_i && wr_addr_i == rd_idx_i)));
endmodule

// File: rtl/rft_counter_chain.sv
module rft_counter_chain #(
  parameter int CLK_W = 19,
  parameter int SYM_W = 8,
  parameter int FRM_W = 40,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [FRM_W-1:0] init_frame_i,
  input  logic [SYM_W-1:0] sym_tc_i,
  input  logic [CLK_W-1:0] tc_i,
  output logic [CLK_W-1:0] clk_cnt_o,
  output logic [SYM_W-1:0] sym_cnt_o,
  output logic [FRM_W-1:0] frm_cnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sym_stb_o,
  output logic             frm_stb_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = '1;
  localparam logic [CLK_W-1:0] CLK_ONE  = CLK_W'(1);
  localparam logic [SYM_W-1:0] SYM_ONE  = SYM_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [FRM_W-1:0] FRM_ONE  = FRM_W'(1);

  logic             run_q;
  logic [CLK_W-1:0] clk_q;
  logic [SYM_W-1:0] sym_q;
  logic [FRM_W-1:0] frm_q;
  logic [IDX_W-1:0] idx_q;
  logic             sstb_q, fstb_q;

  logic clk_end, sym_end;
  assign clk_end = run_q && (clk_q >= tc_i);
  assign sym_end = clk_end && (sym_q >= sym_tc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      clk_q  <= '0;
      sym_q  <= '0;
      frm_q  <= '0;
      idx_q  <= '0;
      sstb_q <= 1'b0;
      fstb_q <= 1'b0;
    end else if (sync_i) begin
      run_q  <= 1'b1;
      clk_q  <= '0;
      sym_q  <= '0;
      idx_q  <= '0;
      frm_q  <= init_frame_i;
      sstb_q <= 1'b0;
      fstb_q <= 1'b0;
    end else begin
      sstb_q <= clk_end;
      fstb_q <= sym_end;
      if (run_q) begin
        if (clk_end) begin
          clk_q <= '0;
          if (sym_end) begin
            sym_q <= '0;
            idx_q <= '0;
            frm_q <= frm_q + FRM_ONE;
          end else begin
            sym_q <= sym_q + SYM_ONE;
            if (idx_q != IDX_LAST) idx_q <= idx_q + IDX_ONE;
          end
        end else begin
          clk_q <= clk_q + CLK_ONE;
        end
      end
    end
  end

  assign clk_cnt_o = clk_q;
  assign sym_cnt_o = sym_q;
  assign frm_cnt_o = frm_q;
  assign idx_o     = idx_q;
  assign sym_stb_o = sstb_q;
  assign frm_stb_o = fstb_q;

  // R1: while idle every count stays at zero
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (clk_q == '0 && sym_q == '0 && idx_q == '0 && !sstb_q));

  // R3: a sync loads the start-of-frame state on the next edge
  p_sync_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (clk_q == '0 && sym_q == '0 && idx_q == '0 && !sstb_q && !fstb_q
                && frm_q == $past(init_frame_i)));

  // R4: below the terminal count the clock count steps by one
  p_clk_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sync_i && clk_q < tc_i) |=> (clk_q == $past(clk_q) + CLK_ONE));

  // R5: the symbol strobe marks the first clock of a symbol
  p_sym_stb_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sstb_q |-> (clk_q == '0));

  // R6: a frame strobe comes with a symbol strobe at symbol zero
  p_frm_stb_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fstb_q |-> (sstb_q && sym_q == '0 && idx_q == '0));

  // R7: the index never runs ahead of the symbol count
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (SYM_W'(idx_q) <= sym_q) || (SYM_W < IDX_W));
endmodule

// File: rtl/radio_frame_timer.sv
module radio_frame_timer
  import rft_pkg::*;
#(
  parameter int CW = CLK_W,
  parameter int SW = SYM_W,
  parameter int FW = FRM_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sync_sel,
  input  logic          sw_sync,
  input  logic          ext_sync,
  input  logic          cmp_sync,
  input  logic [FW-1:0] init_frame,
  input  logic [SW-1:0] sym_tc,
  input  logic          tc_wr_en,
  input  logic [IW-1:0] tc_wr_addr,
  input  logic [CW-1:0] tc_wr_data,
  output logic [CW-1:0] clk_count,
  output logic [SW-1:0] sym_count,
  output logic [FW-1:0] frame_count,
  output logic [IW-1:0] tc_index,
  output logic          sym_strobe,
  output logic          frame_strobe
);
  logic          sync_hit;
  logic [CW-1:0] cur_tc;
  logic [IW-1:0] idx;

  rft_sync_mux u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sync_sel),
    .sw_i   (sw_sync),
    .ext_i  (ext_sync),
    .cmp_i  (cmp_sync),
    .sync_o (sync_hit)
  );

  rft_tc_table #(.IDX_W(IW), .CLK_W(CW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (tc_wr_en),
    .wr_addr_i (tc_wr_addr),
    .wr_data_i (tc_wr_data),
    .rd_idx_i  (idx),
    .rd_tc_o   (cur_tc)
  );

  rft_counter_chain #(.CLK_W(CW), .SYM_W(SW), .FRM_W(FW), .IDX_W(IW)) u_chain (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_hit),
    .init_frame_i (init_frame),
    .sym_tc_i     (sym_tc),
    .tc_i         (cur_tc),
    .clk_cnt_o    (clk_count),
    .sym_cnt_o    (sym_count),
    .frm_cnt_o    (frame_count),
    .idx_o        (idx),
    .sym_stb_o    (sym_strobe),
    .frm_stb_o    (frame_strobe)
  );

  assign tc_index = idx;
endmodule

// File: tb/radio_frame_timer_test.sv
module radio_frame_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sync_sel = 2'd0;
  logic        sw_sync = 1'b0, ext_sync = 1'b0, cmp_sync = 1'b0;
  logic [39:0] init_frame = '0;
  logic [7:0]  sym_tc = '0;
  logic        tc_wr_en = 1'b0;
  logic [6:0]  tc_wr_addr = '0;
  logic [18:0] tc_wr_data = '0;
  logic [18:0] clk_count;
  logic [7:0]  sym_count;
  logic [39:0] frame_count;
  logic [6:0]  tc_index;
  logic        sym_strobe, frame_strobe;

  radio_frame_timer uut (
    .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .sw_sync(sw_sync),
    .ext_sync(ext_sync), .cmp_sync(cmp_sync), .init_frame(init_frame),
    .sym_tc(sym_tc), .tc_wr_en(tc_wr_en), .tc_wr_addr(tc_wr_addr),
    .tc_wr_data(tc_wr_data), .clk_count(clk_count), .sym_count(sym_count),
    .frame_count(frame_count), .tc_index(tc_index), .sym_strobe(sym_strobe),
    .frame_strobe(frame_strobe)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  longint unsigned m_lut[128];
  longint unsigned m_clk, m_sym, m_idx, m_frm;
  bit m_run, m_sstb, m_fstb;
  localparam longint unsigned FMASK = (64'd1 << 40) - 1;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (m_lut[i]) m_lut[i] = 0;
      m_clk = 0; m_sym = 0; m_idx = 0; m_frm = 0;
      m_run = 0; m_sstb = 0; m_fstb = 0;
    end else begin
      bit hit, ns, nf;
      hit = (sync_sel == 2'd0 && sw_sync) || (sync_sel == 2'd1 && ext_sync)
         || (sync_sel == 2'd2 && cmp_sync);
      ns = 0; nf = 0;
      if (hit) begin
        m_run = 1; m_clk = 0; m_sym = 0; m_idx = 0; m_frm = init_frame;
      end else if (m_run) begin
        if (m_clk >= m_lut[m_idx]) begin
          m_clk = 0; ns = 1;
          if (m_sym >= sym_tc) begin
            m_sym = 0; m_idx = 0; m_frm = (m_frm + 1) & FMASK; nf = 1;
          end else begin
            m_sym++;
            if (m_idx < 127) m_idx++;
          end
        end else m_clk++;
      end
      m_sstb = ns; m_fstb = nf;
      if (tc_wr_en) m_lut[tc_wr_addr] = tc_wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(clk_count == m_clk, "R4 clk_count", clk_count, m_clk);
      chk(sym_count == m_sym, "R5 sym_count", sym_count, m_sym);
      chk(sym_strobe == m_sstb, "R5 sym_strobe", sym_strobe, m_sstb);
      chk(frame_count == m_frm, "R6 frame_count", frame_count, m_frm);
      chk(frame_strobe == m_fstb, "R6 frame_strobe", frame_strobe, m_fstb);
      chk(tc_index == m_idx, "R7 tc_index", tc_index, m_idx);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    tc_wr_en = 1; tc_wr_addr = 7'(a); tc_wr_data = 19'(d);
    @(negedge clk);
    tc_wr_en = 0;
  endtask

  task automatic fill(int d);
    for (int a = 0; a < 128; a++) wr(a, d);
  endtask

  // pulse one source; lines 0 sw, 1 ext, 2 cmp
  task automatic pulse(int which);
    @(negedge clk);
    sw_sync = (which == 0); ext_sync = (which == 1); cmp_sync = (which == 2);
    @(negedge clk);
    sw_sync = 0; ext_sync = 0; cmp_sync = 0;
  endtask

  task automatic idle_zero(string tag);
    chk(clk_count == 0 && sym_count == 0 && tc_index == 0 && frame_count == 0
        && !sym_strobe && !frame_strobe, tag,
        longint'(clk_count) + sym_count + tc_index + frame_count, 0);
  endtask

  task automatic sync_loaded(longint unsigned f);
    chk(clk_count == 0 && sym_count == 0 && tc_index == 0, "R3 counts cleared",
        longint'(clk_count) + sym_count + tc_index, 0);
    chk(frame_count == f, "R3 frame loaded", frame_count, f);
  endtask

  task automatic wait_strobe(bit frm, int want_sym, output int at);
    at = -1;
    for (int k = 0; k < 100000; k++) begin
      @(negedge clk);
      if ((frm ? frame_strobe : sym_strobe) && (want_sym < 0 || sym_count == want_sym)) begin
        at = cyc;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, scount;
    tick(3);
    idle_zero("R1 in reset");
    rst_n = 1;
    tick(20);
    idle_zero("R1 idle after reset");

    // unequal short symbols, including a one-cycle one
    for (int a = 0; a < 128; a++) wr(a, (a == 0) ? 3 : (a == 1) ? 1 : (a == 2) ? 5 : (a == 3) ? 0 : 4);
    sym_tc = 8'd4;
    init_frame = 40'd5;
    sync_sel = 2'd0;
    pulse(1); pulse(2);
    idle_zero("R2 unselected sources ignored while idle");
    pulse(0);
    sync_loaded(5);
    tick(60);

    // external source, mid-frame resync; software pulse must be ignored
    sync_sel = 2'd1; init_frame = 40'd100;
    tick(3);
    pulse(0);
    chk(frame_count != 100, "R2 sw ignored under ext select", frame_count, 0);
    pulse(1);
    sync_loaded(100);
    tick(40);

    // compare source
    sync_sel = 2'd2; init_frame = 40'd7;
    pulse(1);
    pulse(2);
    sync_loaded(7);
    tick(30);

    // no source selected
    sync_sel = 2'd3; init_frame = 40'd999;
    tick(5);
    pulse(0); pulse(1); pulse(2);
    chk(frame_count != 999, "R2 none selected ignores all", frame_count, 0);
    tick(20);

    // index saturation with one-cycle symbols
    fill(0);
    sym_tc = 8'd200; sync_sel = 2'd0; init_frame = 40'd1;
    pulse(0);
    tick(150);
    chk(tc_index == 127 && sym_count > 127, "R7 index saturates", tc_index, 127);
    wait_strobe(1, -1, t0);
    chk(tc_index == 0, "R7 index cleared at frame", tc_index, 0);

    // uniform slots: 15 per frame, 150 cycles
    fill(9);
    sym_tc = 8'd14;
    pulse(0);
    wait_strobe(1, -1, t0);
    scount = 0;
    t1 = -1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (sym_strobe) scount++;
      if (frame_strobe) begin t1 = cyc; break; end
    end
    chk(t1 - t0 == 150, "R6 uniform frame length", t1 - t0, 150);
    chk(scount == 15, "R6 slots per frame", scount, 15);

    // 40-bit frame wrap
    sym_tc = 8'd1;
    init_frame = 40'hFF_FFFF_FFFF;
    pulse(0);
    wait_strobe(1, -1, t0);
    chk(frame_count == 0, "R10 frame wrap", frame_count, 0);

    // long symbol plus a rewrite during it
    wr(0, 1); wr(1, 84479); wr(2, 1);
    sym_tc = 8'd2; init_frame = 40'd0;
    pulse(0);
    wait_strobe(0, 1, t0);
    wr(2, 6);
    wait_strobe(0, 2, t1);
    chk(t1 - t0 == 84480, "R8 long symbol length", t1 - t0, 84480);
    wait_strobe(1, -1, t2);
    chk(t2 - t1 == 7, "R9 rewritten entry in running frame", t2 - t1, 7);
    tick(10);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule